// File: doc/BRIEF.md
# Edge-Sensitive Sticky Interrupt Status Field

This block is one interrupt status field of a register bank. It watches a multi-bit trigger input and turns events on that input into status bits. The event may be the level of the trigger, its rising edge, its falling edge, or any change. The way a field holds its status is chosen when it is built:
- **Per-bit sticky:** every bit latches on its own.
- **Whole-field sticky:** the first event vector is captured and then frozen.
- **Non-sticky:** the status simply mirrors the trigger.

Software clears the status in one of two ways, also chosen at build time. With write-one-to-clear, a write strobe carries a data word, and each 1 in that word clears the matching bit. With clear-on-read, a read strobe empties the whole field.

Two qualified summary lines leave the block: an interrupt line and a halt line. Each line has its own qualifier input. Each qualifier is interpreted either as a mask (1 blocks the bit) or as an enable (1 passes the bit). The trigger mode, hold mode, clear method and both qualifier kinds are elaboration parameters. A field therefore carries only the logic its configuration needs.

Top module: `intr_status_field`

## Requirements
- R1: While and after reset, and before any event, status_o is all zeros and irq_o and halt_o are 0.
- R2: Events are seen at a rising clock edge and appear on status_o in the following cycle. In level mode, a bit carries an event while its trigger bit is 1. In rising mode, it carries an event when the trigger bit is 1 and was 0 at the previous edge. In falling mode, it carries an event when the trigger bit is 0 and was 1 at the previous edge. In any-edge mode, it carries an event when the trigger bit differs from its previous value. The previous value resets to 0.
- R3: In per-bit sticky mode, each status bit is set by its own event and stays set, whatever the trigger does, until software clears it.
- R4: In whole-field sticky mode, while the status is all zeros, an event on any bit loads the status with the vector of bits that showed the event. While the status is nonzero, further events leave it unchanged.
- R5: In non-sticky mode, status_o equals the trigger sampled at the previous clock edge, and software clears have no effect.
- R6: In write-one-to-clear mode, sw_wr_en_i clears every status bit whose sw_wr_data_i bit is 1 at the next edge. Bits written 0 keep their value, and sw_rd_en_i has no effect.
- R7: In clear-on-read mode, sw_rd_en_i clears the whole field at the next edge, and writes have no effect.
- R8: When a clear and a new event on the same bit fall in the same cycle, the event wins and the bit is set. In whole-field mode, an event in the cycle that empties the field is captured.
- R9: irq_o is the OR over all bits of status AND NOT irq_qual_i in mask mode, or of status AND irq_qual_i in enable mode.
- R10: halt_o is the OR over all bits of status qualified by halt_qual_i. It uses its own mask-or-enable choice, independent of the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | WIDTH | Event trigger vector |
| sw_wr_en_i | input | 1 | Software write strobe |
| sw_wr_data_i | input | WIDTH | Software write data (1 clears in write-one-to-clear mode) |
| sw_rd_en_i | input | 1 | Software read strobe (clears in clear-on-read mode) |
| irq_qual_i | input | WIDTH | Interrupt mask or enable per bit |
| halt_qual_i | input | WIDTH | Halt mask or enable per bit |
| status_o | output | WIDTH | Interrupt status field |
| irq_o | output | 1 | Qualified interrupt line |
| halt_o | output | 1 | Qualified halt line |

## Verification
Two things can fall in the same cycle: a software clear and a fresh trigger event on the same bit. The bench provokes this by raising a trigger bit in the very cycle a write-one-to-clear strobe targets it. The set must survive. In whole-field mode, the clear that empties the field is combined with an edge on a different bit, so the newly captured vector is visibly distinct from the old one. Around this collision, the bench sweeps every pair of old and new 4-bit trigger values through four differently configured instances and compares status and both summary lines against values derived arithmetically from the pair.

// File: rtl/intr_field_pkg.sv
package intr_field_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_ANY
  } trig_mode_e;

  typedef enum logic [1:0] {
    HOLD_PER_BIT,
    HOLD_WHOLE,
    HOLD_NONE
  } hold_mode_e;

  typedef enum logic {
    QUAL_MASK,
    QUAL_ENABLE
  } qual_kind_e;

  typedef enum logic {
    CLR_W1C,
    CLR_ON_READ
  } clr_kind_e;

endpackage

// File: rtl/intr_edge_detect.sv
module intr_edge_detect
  import intr_field_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter trig_mode_e TRIG_MODE = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] trig_i,
  output logic [WIDTH-1:0] event_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic             prev_en;

  // previous trigger sample, refreshed every cycle
  always_comb begin
    prev_d  = trig_i;
    prev_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    case (TRIG_MODE)
      TRIG_LEVEL: event_o = trig_i;
      TRIG_RISE:  event_o = trig_i & ~prev_q;
      TRIG_FALL:  event_o = ~trig_i & prev_q;
      default:    event_o = trig_i ^ prev_q;
    endcase
  end

endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
  import intr_field_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter hold_mode_e HOLD_MODE = HOLD_PER_BIT,
  parameter clr_kind_e  CLR_KIND  = CLR_W1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] event_i,
  input  logic [WIDTH-1:0] trig_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] clr_vec;
  logic [WIDTH-1:0] kept;
  logic             status_en;

  // software clear vector
  always_comb begin
    case (CLR_KIND)
      CLR_W1C: clr_vec = wr_en_i ? wr_data_i : '0;
      default: clr_vec = rd_en_i ? {WIDTH{1'b1}} : '0;
    endcase
  end

  // the clear is applied first so that a same-cycle event overrides it
  always_comb begin
    kept = status_q & ~clr_vec;
    case (HOLD_MODE)
      HOLD_PER_BIT: status_d = kept | event_i;
      HOLD_WHOLE:   status_d = ((kept == '0) && (|event_i)) ? event_i : kept;
      default:      status_d = trig_i;
    endcase
    status_en = (HOLD_MODE == HOLD_NONE) || (|clr_vec) || (|event_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/intr_qualify.sv
module intr_qualify
  import intr_field_pkg::*;
#(
  parameter int         WIDTH = 4,
  parameter qual_kind_e KIND  = QUAL_MASK
) (
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] qual_i,
  output logic             line_o
);

  logic [WIDTH-1:0] pass_bits;

  generate
    if (KIND == QUAL_MASK) begin : g_mask
      assign pass_bits = status_i & ~qual_i;
    end else begin : g_enable
      assign pass_bits = status_i & qual_i;
    end
  endgenerate

  assign line_o = |pass_bits;

endmodule

// File: rtl/intr_status_field.sv
module intr_status_field
  import intr_field_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter trig_mode_e TRIG_MODE = TRIG_RISE,
  parameter hold_mode_e HOLD_MODE = HOLD_PER_BIT,
  parameter clr_kind_e  CLR_KIND  = CLR_W1C,
  parameter qual_kind_e IRQ_QUAL  = QUAL_MASK,
  parameter qual_kind_e HALT_QUAL = QUAL_ENABLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] trig_i,
  input  logic             sw_wr_en_i,
  input  logic [WIDTH-1:0] sw_wr_data_i,
  input  logic             sw_rd_en_i,
  input  logic [WIDTH-1:0] irq_qual_i,
  input  logic [WIDTH-1:0] halt_qual_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o,
  output logic             halt_o
);

  logic [WIDTH-1:0] event_vec;

  intr_edge_detect #(
    .WIDTH    (WIDTH),
    .TRIG_MODE(TRIG_MODE)
  ) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .event_o(event_vec)
  );

  intr_status_reg #(
    .WIDTH    (WIDTH),
    .HOLD_MODE(HOLD_MODE),
    .CLR_KIND (CLR_KIND)
  ) stat_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (event_vec),
    .trig_i   (trig_i),
    .wr_en_i  (sw_wr_en_i),
    .wr_data_i(sw_wr_data_i),
    .rd_en_i  (sw_rd_en_i),
    .status_o (status_o)
  );

  intr_qualify #(
    .WIDTH(WIDTH),
    .KIND (IRQ_QUAL)
  ) irq_q_i (
    .status_i(status_o),
    .qual_i  (irq_qual_i),
    .line_o  (irq_o)
  );

  intr_qualify #(
    .WIDTH(WIDTH),
    .KIND (HALT_QUAL)
  ) halt_q_i (
    .status_i(status_o),
    .qual_i  (halt_qual_i),
    .line_o  (halt_o)
  );

endmodule

// File: rtl/intr_status_field_chk.sv
module intr_status_field_chk
  import intr_field_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter trig_mode_e TRIG_MODE = TRIG_RISE,
  parameter hold_mode_e HOLD_MODE = HOLD_PER_BIT,
  parameter clr_kind_e  CLR_KIND  = CLR_W1C,
  parameter qual_kind_e IRQ_QUAL  = QUAL_MASK,
  parameter qual_kind_e HALT_QUAL = QUAL_ENABLE
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] trig_i,
  input logic             sw_wr_en_i,
  input logic [WIDTH-1:0] sw_wr_data_i,
  input logic             sw_rd_en_i,
  input logic [WIDTH-1:0] irq_qual_i,
  input logic [WIDTH-1:0] halt_qual_i,
  input logic [WIDTH-1:0] status_o,
  input logic             irq_o,
  input logic             halt_o
);

  logic clr_req;
  assign clr_req = (CLR_KIND == CLR_W1C) ? (sw_wr_en_i && (|sw_wr_data_i)) : sw_rd_en_i;

  generate
    if (TRIG_MODE == TRIG_RISE) begin : g_rise
      // R2
      rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_o & ~$past(status_o) & ~$past(trig_i)) == '0));
    end
    if (TRIG_MODE == TRIG_FALL) begin : g_fall
      // R2
      fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_o & ~$past(status_o) & $past(trig_i)) == '0));
    end
    if (HOLD_MODE == HOLD_PER_BIT) begin : g_pb
      // R3
      bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((status_o & $past(status_o)) == $past(status_o)));
    end
    if (HOLD_MODE == HOLD_WHOLE) begin : g_wh
      // R4
      whole_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o != '0) && !clr_req) |=> $stable(status_o));
    end
    if (HOLD_MODE == HOLD_NONE) begin : g_nn
      // R5
      follow_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status_o == $past(trig_i)));
    end
    if (IRQ_QUAL == QUAL_MASK) begin : g_im
      // R9
      irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_qual_i == {WIDTH{1'b1}}) |-> !irq_o);
    end else begin : g_ie
      // R9
      irq_none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_qual_i == '0) |-> !irq_o);
    end
    if (HALT_QUAL == QUAL_MASK) begin : g_hm
      // R10
      halt_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_qual_i == {WIDTH{1'b1}}) |-> !halt_o);
    end else begin : g_he
      // R10
      halt_none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_qual_i == '0) |-> !halt_o);
    end
  endgenerate

  // R9
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0));

  // R10
  halt_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (status_o != '0));

endmodule

bind intr_status_field intr_status_field_chk #(
  .WIDTH    (WIDTH),
  .TRIG_MODE(TRIG_MODE),
  .HOLD_MODE(HOLD_MODE),
  .CLR_KIND (CLR_KIND),
  .IRQ_QUAL (IRQ_QUAL),
  .HALT_QUAL(HALT_QUAL)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .sw_wr_en_i  (sw_wr_en_i),
  .sw_wr_data_i(sw_wr_data_i),
  .sw_rd_en_i  (sw_rd_en_i),
  .irq_qual_i  (irq_qual_i),
  .halt_qual_i (halt_qual_i),
  .status_o    (status_o),
  .irq_o       (irq_o),
  .halt_o      (halt_o)
);

// File: tb/intr_status_field_tb_top.sv
module intr_status_field_tb_top;
  import intr_field_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [3:0] trig;
  logic       wr_en;
  logic [3:0] wr_data;
  logic       rd_en;
  logic [3:0] iq;
  logic [3:0] hq;

  logic [3:0] st_i, st_f, st_b, st_n;
  logic       irq_i, irq_f, irq_b, irq_n;
  logic       hlt_i, hlt_f, hlt_b, hlt_n;

  int n_chk;
  int n_fail;

  // rising, per-bit, write-one-to-clear, irq mask, halt enable
  intr_status_field #(.WIDTH(4), .TRIG_MODE(TRIG_RISE), .HOLD_MODE(HOLD_PER_BIT),
    .CLR_KIND(CLR_W1C), .IRQ_QUAL(QUAL_MASK), .HALT_QUAL(QUAL_ENABLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_wr_en_i(wr_en), .sw_wr_data_i(wr_data),
    .sw_rd_en_i(rd_en), .irq_qual_i(iq), .halt_qual_i(hq),
    .status_o(st_i), .irq_o(irq_i), .halt_o(hlt_i));

  // falling, per-bit, clear-on-read, irq enable, halt mask
  intr_status_field #(.WIDTH(4), .TRIG_MODE(TRIG_FALL), .HOLD_MODE(HOLD_PER_BIT),
    .CLR_KIND(CLR_ON_READ), .IRQ_QUAL(QUAL_ENABLE), .HALT_QUAL(QUAL_MASK)) dut_f (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_wr_en_i(wr_en), .sw_wr_data_i(wr_data),
    .sw_rd_en_i(rd_en), .irq_qual_i(iq), .halt_qual_i(hq),
    .status_o(st_f), .irq_o(irq_f), .halt_o(hlt_f));

  // any edge, whole-field, write-one-to-clear, irq enable, halt mask
  intr_status_field #(.WIDTH(4), .TRIG_MODE(TRIG_ANY), .HOLD_MODE(HOLD_WHOLE),
    .CLR_KIND(CLR_W1C), .IRQ_QUAL(QUAL_ENABLE), .HALT_QUAL(QUAL_MASK)) dut_b (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_wr_en_i(wr_en), .sw_wr_data_i(wr_data),
    .sw_rd_en_i(rd_en), .irq_qual_i(iq), .halt_qual_i(hq),
    .status_o(st_b), .irq_o(irq_b), .halt_o(hlt_b));

  // level, non-sticky, write-one-to-clear, irq mask, halt enable
  intr_status_field #(.WIDTH(4), .TRIG_MODE(TRIG_LEVEL), .HOLD_MODE(HOLD_NONE),
    .CLR_KIND(CLR_W1C), .IRQ_QUAL(QUAL_MASK), .HALT_QUAL(QUAL_ENABLE)) dut_n (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_wr_en_i(wr_en), .sw_wr_data_i(wr_data),
    .sw_rd_en_i(rd_en), .irq_qual_i(iq), .halt_qual_i(hq),
    .status_o(st_n), .irq_o(irq_n), .halt_o(hlt_n));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b1;
    trig = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; iq = '0; hq = '0;
    #1 rst_n = 1'b0;
    cyc(); cyc();
    chk("R1 status_i in reset", st_i, 0);
    rst_n = 1'b1;
    cyc(); cyc();
    // R1 state after reset, trigger held low (also no falling edge seen: R2)
    chk("R1 status_i", st_i, 0);
    chk("R1 R2 status_f", st_f, 0);
    chk("R1 status_b", st_b, 0);
    chk("R1 status_n", st_n, 0);
    chk("R1 irq", {irq_i, irq_f, irq_b, irq_n}, 0);
    chk("R1 halt", {hlt_i, hlt_f, hlt_b, hlt_n}, 0);

    // sweep every old/new trigger pair
    for (int o = 0; o < 16; o++) begin
      for (int nw = 0; nw < 16; nw++) begin
        logic [3:0] ov, nv;
        ov = 4'(o);
        nv = 4'(nw);
        trig = ov; iq = ov; hq = nv;
        cyc();
        wr_en = 1'b1; wr_data = 4'hF; rd_en = 1'b1;
        cyc();
        wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        chk("R6 W1C clear dut_i", st_i, 0);
        chk("R7 read clear dut_f", st_f, 0);
        chk("R6 W1C clear dut_b", st_b, 0);
        chk("R5 clear ignored dut_n", st_n, ov);
        trig = nv;
        cyc();
        chk("R2 R3 rise dut_i", st_i, nv & ~ov);
        chk("R2 R3 fall dut_f", st_f, ov & ~nv);
        chk("R2 R4 any-edge capture dut_b", st_b, ov ^ nv);
        chk("R2 R5 level follow dut_n", st_n, nv);
        chk("R9 irq mask dut_i", irq_i, |(nv & ~ov & ~ov));
        chk("R10 halt enable dut_i", hlt_i, |(nv & ~ov & nv));
        chk("R9 irq enable dut_f", irq_f, |(ov & ~nv & ov));
        chk("R10 halt mask dut_f", hlt_f, |(ov & ~nv & ~nv));
        chk("R9 irq enable dut_b", irq_b, |((ov ^ nv) & ov));
        chk("R10 halt mask dut_b", hlt_b, |((ov ^ nv) & ~nv));
        chk("R9 irq mask dut_n", irq_n, |(nv & ~ov));
        chk("R10 halt enable dut_n", hlt_n, |nv);
        trig = ov;
        cyc();
        chk("R3 accumulate dut_i", st_i, ov ^ nv);
        chk("R3 accumulate dut_f", st_f, ov ^ nv);
        chk("R4 hold dut_b", st_b, ov ^ nv);
        chk("R5 follow dut_n", st_n, ov);
      end
    end

    // directed collisions and clear corner cases
    iq = '0; hq = '0;
    trig = 4'h0;
    cyc();
    wr_en = 1'b1; wr_data = 4'hF; rd_en = 1'b1;
    cyc();
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    trig = 4'h1;
    cyc();
    chk("R3 set dut_i", st_i, 1);
    chk("R4 capture dut_b", st_b, 1);
    trig = 4'h0;
    cyc();
    chk("R3 hold after trigger drops dut_i", st_i, 1);
    chk("R2 fall dut_f", st_f, 1);
    trig = 4'h1; wr_en = 1'b1; wr_data = 4'h1;
    cyc();
    chk("R8 event beats clear dut_i", st_i, 1);
    chk("R8 capture in emptying cycle dut_b", st_b, 1);
    chk("R7 write ignored dut_f", st_f, 1);
    wr_data = 4'h0;
    cyc();
    chk("R6 zero bits no effect dut_i", st_i, 1);
    chk("R6 zero bits no effect dut_b", st_b, 1);
    wr_en = 1'b0; rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    chk("R6 read ignored dut_i", st_i, 1);
    chk("R6 read ignored dut_b", st_b, 1);
    chk("R7 read clears dut_f", st_f, 0);
    wr_en = 1'b1; wr_data = 4'h1;
    cyc();
    wr_en = 1'b0; wr_data = '0;
    chk("R6 clear bit0 dut_i", st_i, 0);
    chk("R6 clear bit0 dut_b", st_b, 0);
    trig = 4'h3;
    cyc();
    chk("R4 capture bit1 dut_b", st_b, 4'h2);
    chk("R3 rise bit1 dut_i", st_i, 4'h2);
    trig = 4'h7;
    cyc();
    chk("R4 later event ignored dut_b", st_b, 4'h2);
    chk("R3 second bit dut_i", st_i, 4'h6);
    trig = 4'hF; wr_en = 1'b1; wr_data = 4'h2;
    cyc();
    wr_en = 1'b0; wr_data = '0;
    chk("R8 new vector captured dut_b", st_b, 4'h8);
    chk("R6 R8 partial clear plus event dut_i", st_i, 4'hC);

    finish_run();
  end

endmodule